// File: doc/BRIEF.md
# Receive High Bit-Error-Rate Monitor

This block watches the two-bit synchronisation header of every received 64b/66b block. It decides whether the link is too noisy to trust. A header whose two bits are equal cannot occur on a clean link. The block counts such headers inside a fixed measurement window. When the count reaches a threshold (97 by default), it raises a high-error flag at once. The flag stays up until a whole window passes with fewer errors than the threshold. The window length is a parameter counted in timer ticks, so one block serves both link speeds. The typical settings are about 500 µs for the faster rate and 1.25 ms for the slower one. A short window can be used for simulation.

Monitoring only runs while the lane-alignment input reports the lanes deskewed and aligned. When alignment is lost, the window and the error count restart and the flag clears. A second output tells the downstream decoder whether to accept blocks. Blocks are accepted only while alignment holds and the flag is low.

Top module: `pcs_ber_monitor`

## Requirements
- R1: A header is invalid when hdr_i is 2'b00 or 2'b11; 2'b01 and 2'b10 are valid. A header is counted only in a cycle where hdr_vld_i and align_i are both high.
- R2: hi_ber_o rises at the clock edge that takes in the invalid header bringing the window's count to THRESH. It does not wait for the window to end.
- R3: A window ends at the edge where align_i and tick_i are high and WIN_TICKS ticks have elapsed since the window began. If that window's count (including the header taken at that edge) is below THRESH, hi_ber_o falls at that edge.
- R4: At each window end the count restarts from zero. Invalid headers in neighbouring windows are never added together.
- R5: The window timer advances only in cycles with tick_i high. Cycles with tick_i low do not shorten the window.
- R6: When align_i is low at an edge, hi_ber_o goes low and the window timer and the count restart from zero.
- R7: accept_o is registered. After each edge it equals align_i (as sampled at that edge) AND NOT the new hi_ber_o.
- R8: Within a window the count saturates at THRESH. If a window ends with the count at THRESH, hi_ber_o stays high into the next window.
- R9: While rst is high, and after it, until the next edge, hi_ber_o and accept_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Window timer enable, one count per high cycle |
| hdr_i | input | 2 | Synchronisation header of the current block |
| hdr_vld_i | input | 1 | hdr_i carries a header this cycle |
| align_i | input | 1 | Lanes locked, deskewed and aligned |
| hi_ber_o | output | 1 | High bit-error-rate condition |
| accept_o | output | 1 | Decoder may accept blocks |

## Verification
The bench first sends only valid headers, to show that no error counting happens on a clean stream. Invalid headers without the strobe are mixed with strobed ones, which shows that only strobed headers are counted. Exactly THRESH errors and THRESH-1 errors are placed in one window, which tests the exact threshold edge. Errors split across a window boundary show that counts restart at each window. Long stretches with tick_i low show that the window is measured in ticks and not in clock cycles. Dropping alignment while the flag is high shows the immediate clearing path. A run of quiet windows after an error burst shows both hold (saturated count) and release.

// File: rtl/pcs_ber_pkg.sv
package pcs_ber_pkg;

  typedef logic [1:0] sync_hdr_t;

  // equal bits mean the header could not have been sent on a clean line
  function automatic logic hdr_is_bad(input sync_hdr_t h);
    return (h[1] == h[0]);
  endfunction

endpackage

// File: rtl/pcs_ber_hdr_check.sv
module pcs_ber_hdr_check
  import pcs_ber_pkg::*;
(
  input  sync_hdr_t hdr_i,
  input  logic      hdr_vld_i,
  input  logic      align_i,
  output logic      bad_o
);

  always_comb begin
    bad_o = align_i && hdr_vld_i && hdr_is_bad(hdr_i);
  end

endmodule

// File: rtl/pcs_ber_win_timer.sv
module pcs_ber_win_timer #(
  parameter int unsigned WIN_TICKS = 195313,
  localparam int unsigned TW = (WIN_TICKS > 1) ? $clog2(WIN_TICKS) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic align_i,
  input  logic tick_i,
  output logic win_end_o
);

  localparam logic [TW-1:0] LAST = TW'(WIN_TICKS - 1);

  logic [TW-1:0] tmr_q;

  always_comb begin
    win_end_o = align_i && tick_i && (tmr_q == LAST);
  end

  always_ff @(posedge clk) begin
    if (rst || !align_i) begin
      tmr_q <= '0;
    end else if (tick_i) begin
      if (tmr_q == LAST) tmr_q <= '0;
      else               tmr_q <= tmr_q + 1'b1;
    end
  end

endmodule

// File: rtl/pcs_ber_err_count.sv
module pcs_ber_err_count #(
  parameter int unsigned THRESH = 97,
  localparam int unsigned CW = $clog2(THRESH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          align_i,
  input  logic          bad_i,
  input  logic          win_end_i,
  output logic [CW-1:0] cnt_next_o,
  output logic          at_thresh_o
);

  localparam logic [CW-1:0] TOP = CW'(THRESH);

  logic [CW-1:0] cnt_q;

  always_comb begin
    if (bad_i && cnt_q != TOP) cnt_next_o = cnt_q + 1'b1;
    else                       cnt_next_o = cnt_q;
    at_thresh_o = (cnt_next_o == TOP);
  end

  always_ff @(posedge clk) begin
    if (rst || !align_i || win_end_i) cnt_q <= '0;
    else                              cnt_q <= cnt_next_o;
  end

endmodule

// File: rtl/pcs_ber_monitor.sv
module pcs_ber_monitor
  import pcs_ber_pkg::*;
#(
  parameter int unsigned WIN_TICKS = 195313,
  parameter int unsigned THRESH    = 97
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_i,
  input  logic [1:0] hdr_i,
  input  logic       hdr_vld_i,
  input  logic       align_i,
  output logic       hi_ber_o,
  output logic       accept_o
);

  localparam int unsigned CW = $clog2(THRESH + 1);

  logic          bad;
  logic          win_end;
  logic [CW-1:0] cnt_next;
  logic          at_thresh;
  logic          hi_next;

  pcs_ber_hdr_check u_chk (
    .hdr_i     (sync_hdr_t'(hdr_i)),
    .hdr_vld_i (hdr_vld_i),
    .align_i   (align_i),
    .bad_o     (bad)
  );

  pcs_ber_win_timer #(.WIN_TICKS(WIN_TICKS)) u_tmr (
    .clk       (clk),
    .rst       (rst),
    .align_i   (align_i),
    .tick_i    (tick_i),
    .win_end_o (win_end)
  );

  pcs_ber_err_count #(.THRESH(THRESH)) u_cnt (
    .clk         (clk),
    .rst         (rst),
    .align_i     (align_i),
    .bad_i       (bad),
    .win_end_i   (win_end),
    .cnt_next_o  (cnt_next),
    .at_thresh_o (at_thresh)
  );

  // the threshold wins over the window end; a quiet window end clears
  always_comb begin
    if (!align_i)       hi_next = 1'b0;
    else if (at_thresh) hi_next = 1'b1;
    else if (win_end)   hi_next = 1'b0;
    else                hi_next = hi_ber_o;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_ber_o <= 1'b0;
      accept_o <= 1'b0;
    end else begin
      hi_ber_o <= hi_next;
      accept_o <= align_i && !hi_next;
    end
  end

endmodule

// File: rtl/pcs_ber_monitor_chk.sv
module pcs_ber_monitor_chk #(
  parameter int unsigned THRESH = 97,
  localparam int unsigned CW = $clog2(THRESH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic [1:0]    hdr_i,
  input logic          hdr_vld_i,
  input logic          align_i,
  input logic          hi_ber_o,
  input logic          accept_o,
  input logic          win_end,
  input logic [CW-1:0] cnt_next
);

  a_r6_align_loss_clears: assert property (@(posedge clk) disable iff (rst)
    !align_i |=> !hi_ber_o);

  a_r7_accept_needs_clean: assert property (@(posedge clk) disable iff (rst)
    accept_o |-> !hi_ber_o);

  a_r7_accept_needs_align: assert property (@(posedge clk) disable iff (rst)
    !align_i |=> !accept_o);

  a_r2_rise_on_bad_header: assert property (@(posedge clk) disable iff (rst)
    $rose(hi_ber_o) |-> $past(align_i && hdr_vld_i && (hdr_i[1] == hdr_i[0])));

  a_r3_fall_at_boundary: assert property (@(posedge clk) disable iff (rst)
    $fell(hi_ber_o) |-> $past(!align_i || win_end));

  a_r8_count_saturates: assert property (@(posedge clk) disable iff (rst)
    cnt_next <= CW'(THRESH));

endmodule

bind pcs_ber_monitor pcs_ber_monitor_chk #(.THRESH(THRESH)) u_chk_bind (
  .clk       (clk),
  .rst       (rst),
  .hdr_i     (hdr_i),
  .hdr_vld_i (hdr_vld_i),
  .align_i   (align_i),
  .hi_ber_o  (hi_ber_o),
  .accept_o  (accept_o),
  .win_end   (win_end),
  .cnt_next  (cnt_next)
);

// File: tb/pcs_ber_monitor_tb.sv
module pcs_ber_monitor_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WIN = 256;
  localparam int TH  = 97;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_i = 1'b0;
  logic [1:0] hdr_i = 2'b01;
  logic       hdr_vld_i = 1'b0;
  logic       align_i = 1'b0;
  logic       hi_ber_o, accept_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcs_ber_monitor #(.WIN_TICKS(WIN), .THRESH(TH)) u_dut (
    .clk(clk), .rst(rst), .tick_i(tick_i), .hdr_i(hdr_i),
    .hdr_vld_i(hdr_vld_i), .align_i(align_i),
    .hi_ber_o(hi_ber_o), .accept_o(accept_o)
  );

  int n_vec = 0;
  int n_bad = 0;
  string cur_tag = "R9";

  // reference state built from the requirements
  int m_tmr = 0;
  int m_cnt = 0;
  bit m_hi  = 0;

  logic [1:0] exp_q[$];
  string      tag_q[$];

  task automatic cyc(input logic [1:0] h, input bit v, input bit al, input bit tk);
    bit bad, wend;
    int nc;
    @(negedge clk);
    hdr_i = h; hdr_vld_i = v; align_i = al; tick_i = tk;
    @(posedge clk);
    bad  = al && v && (h[1] == h[0]);
    wend = al && tk && (m_tmr == WIN-1);
    nc   = m_cnt + (bad ? 1 : 0);
    if (nc > TH) nc = TH;
    if (!al) begin
      m_tmr = 0; m_cnt = 0; m_hi = 0;
    end else begin
      if (nc == TH)  m_hi = 1;
      else if (wend) m_hi = 0;
      if (tk) m_tmr = wend ? 0 : m_tmr + 1;
      m_cnt = wend ? 0 : nc;
    end
    exp_q.push_back({m_hi, bit'(al && !m_hi)});
    tag_q.push_back(cur_tag);
  endtask

  task automatic run(input int n, input logic [1:0] h, input bit v, input bit tk);
    for (int i = 0; i < n; i++) cyc(h, v, 1'b1, tk);
  endtask

  // monitor: compares the outputs half a cycle after each edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_vec++;
      if ({hi_ber_o, accept_o} !== e) begin
        n_bad++;
        $display("FAIL %s: {hi_ber,accept} got %b expected %b at %0t",
                 t, {hi_ber_o, accept_o}, e, $time);
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_vec++;
    if ({hi_ber_o, accept_o} !== 2'b00) begin   // R9
      n_bad++;
      $display("FAIL R9: reset outputs got %b expected 00", {hi_ber_o, accept_o});
    end
    rst = 1'b0;

    // R7: clean stream, accept follows alignment
    cur_tag = "R7";
    cyc(2'b01, 1, 0, 1);
    run(40, 2'b01, 1, 1);
    run(40, 2'b10, 1, 1);

    // R1: unstrobed invalid headers ignored; then 96 strobed ones stay below threshold
    cur_tag = "R1";
    cyc(2'b00, 1, 0, 1);
    run(60, 2'b11, 0, 1);
    run(48, 2'b00, 1, 1);
    run(48, 2'b11, 1, 1);
    run(20, 2'b01, 1, 1);

    // R2: exactly THRESH in a fresh window raises the flag at once
    cur_tag = "R2";
    cyc(2'b01, 1, 0, 1);
    run(TH-1, 2'b00, 1, 1);
    run(10, 2'b10, 1, 1);
    run(1, 2'b11, 1, 1);
    run(20, 2'b01, 1, 1);

    // R8: saturated count carries the flag over the boundary
    cur_tag = "R8";
    run(200, 2'b00, 1, 1);
    run(30, 2'b01, 1, 1);

    // R3: a quiet window clears the flag at its end
    cur_tag = "R3";
    run(2*WIN, 2'b10, 1, 1);

    // R4: errors split across a boundary do not add up
    cur_tag = "R4";
    cyc(2'b01, 1, 0, 1);
    run(WIN-TH+1, 2'b01, 1, 1);
    run(TH-1, 2'b00, 1, 1);
    run(TH-1, 2'b11, 1, 1);
    run(20, 2'b01, 1, 1);

    // R5: tick low freezes the window, errors spread in time still accumulate
    cur_tag = "R5";
    cyc(2'b01, 1, 0, 1);
    for (int i = 0; i < TH; i++) begin
      cyc(2'b00, 1, 1, 1);
      cyc(2'b01, 1, 1, 0);
      cyc(2'b01, 1, 1, 0);
      cyc(2'b01, 1, 1, 0);
    end
    run(20, 2'b01, 1, 0);

    // R6: losing alignment clears the flag and restarts counting
    cur_tag = "R6";
    cyc(2'b01, 1, 0, 1);
    cyc(2'b01, 1, 0, 1);
    run(TH-1, 2'b11, 1, 1);
    cyc(2'b00, 1, 0, 1);
    run(5, 2'b00, 1, 1);
    run(20, 2'b01, 1, 1);

    cur_tag = "R7";
    cyc(2'b01, 1, 0, 1);
    @(negedge clk);
    @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule